// File: doc/BRIEF.md
# Dual-Word Frequency Alternator for a Direct Digital Synthesizer

This block keeps a direct digital synthesizer fed with two 32-bit tuning words. The two words sit a fixed step of about 1400 Hz apart. They come from two base words, and a single signed user offset is added to both. The block also drives a select line that swings the synthesizer between the two words at a fixed rate with an even duty cycle. A synchronous detector downstream uses this line as its reference.

A write of both words goes out over a plain SPI write whenever the update strobe fires. The same write also repeats by itself after a long quiet interval, so the synthesizer's copy of the words is refreshed. With a 20 MHz clock, the select period is 48,000 cycles. The default base words, 0x440262F6 and 0x43FDCC8E, give about 5.313228 MHz and 5.311828 MHz at a step of 20 MHz / 2^32.

Top module: `dds_word_alternator`

## Requirements
- R1: While reset is held, and at its release, the outputs are as follows: `spi_cs_n` is 1, `spi_sclk` is 0, `spi_mosi` is 0, `fsel` is 0 and `busy` is 0.
- R2: `fsel` inverts on every TOGGLE_CYC-th clock edge after reset and holds its value between those edges, so its duty is exactly 50%. After n edges, `fsel` equals bit 0 of n / TOGGLE_CYC.
- R3: The words sent are `base_a + offset` and `base_b + offset`. The offset is read as two's complement, and both sums wrap modulo 2^32.
- R4: An `upd` pulse seen on a clock edge while the block is idle starts a write at that same edge, so `busy` is 1 after it. A write is two frames, the A word first and then the B word. `busy` stays 1 until both frames are done.
- R5: Each frame is `spi_cs_n` low for exactly 32 SCLK periods. Data is MSB first, and `spi_mosi` changes only while `spi_sclk` is low, so the receiver samples on the rising SCLK edge. Each SCLK half-period is SCLK_DIV clocks. The second frame's chip select falls exactly 65*SCLK_DIV clocks after the first frame's does.
- R6: Both words are captured when the write starts. Changes to `offset` or the base words during the write do not alter the frames of that write.
- R7: An `upd` pulse during a write is held. One further write, using the values current when it starts, follows right after the running write ends.
- R8: With no strobe, a write starts exactly REFRESH_CYC clocks after the previous write started, carrying the current inputs.
- R9: While `spi_cs_n` is high, `spi_sclk` and `spi_mosi` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (20 MHz in the target system) |
| rst_n | input | 1 | Active-low synchronous reset |
| base_a | input | 32 | Base tuning word A |
| base_b | input | 32 | Base tuning word B |
| offset | input | 32 | Signed offset added to both words |
| upd | input | 1 | Request a write of both words |
| spi_sclk | output | 1 | SPI serial clock, idle low |
| spi_mosi | output | 1 | SPI data, MSB first |
| spi_cs_n | output | 1 | Active-low frame select |
| fsel | output | 1 | Word select to the synthesizer (0 = A, 1 = B) |
| busy | output | 1 | A two-frame write is in progress |

## Verification
The bench sweeps offsets at the signed extremes (0x7FFFFFFF, 0x80000000, -1) over a base pair chosen to wrap through zero. A design that extended or saturated the offset would send wrong words there. It moves the offset partway through a write and also strobes during that write. A block that re-read its inputs mid-frame, dropped the held request, or ran it twice would send a mismatched first pair or the wrong number of frames. The chip-select fall times are logged in clock cycles. This shows an off-by-one in the inter-frame gap or in the refresh interval as a wrong cycle count. The select line is compared cycle by cycle against the edge count, both before and after SPI traffic, which exposes a wrong toggle count or any coupling to the SPI side.

// File: rtl/dds_word_alternator.sv
module dds_word_alternator #(
  parameter int WORD_W      = 32,
  parameter int TOGGLE_CYC  = 24000,
  parameter int REFRESH_CYC = 60000000,
  parameter int SCLK_DIV    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] base_a,
  input  logic [WORD_W-1:0] base_b,
  input  logic [WORD_W-1:0] offset,
  input  logic              upd,
  output logic              spi_sclk,
  output logic              spi_mosi,
  output logic              spi_cs_n,
  output logic              fsel,
  output logic              busy
);
  localparam int TW = $clog2(TOGGLE_CYC + 1);
  localparam int RW = $clog2(REFRESH_CYC + 1);
  localparam int DW = $clog2(SCLK_DIV + 1);
  localparam int BW = $clog2(WORD_W);
  localparam logic [TW-1:0] TOG_LAST = TW'(TOGGLE_CYC - 1);
  localparam logic [RW-1:0] REF_LAST = RW'(REFRESH_CYC - 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(SCLK_DIV - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(WORD_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} st_t;

  logic [TW-1:0]     tcnt;
  logic [RW-1:0]     rcnt;
  logic [DW-1:0]     div;
  logic [BW-1:0]     bcnt;
  logic [WORD_W-1:0] sh, word_b;
  logic              second, pend;
  st_t               st;

  wire [WORD_W-1:0] sum_a = base_a + offset;
  wire [WORD_W-1:0] sum_b = base_b + offset;
  wire tick    = (rcnt == REF_LAST);
  wire req     = upd | tick;
  wire start   = (st == S_IDLE) && (req || pend);
  wire div_end = (div == DIV_LAST);

  assign spi_mosi = !spi_cs_n && sh[WORD_W-1];
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt <= '0;
      fsel <= 1'b0;
    end else if (tcnt == TOG_LAST) begin
      tcnt <= '0;
      fsel <= ~fsel;
    end else begin
      tcnt <= tcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcnt     <= '0;
      pend     <= 1'b0;
      st       <= S_IDLE;
      sh       <= '0;
      word_b   <= '0;
      second   <= 1'b0;
      bcnt     <= '0;
      div      <= '0;
      spi_cs_n <= 1'b1;
      spi_sclk <= 1'b0;
    end else begin
      if (start)      rcnt <= '0;
      else if (!tick) rcnt <= rcnt + 1'b1;

      if (start)      pend <= 1'b0;
      else if (req)   pend <= 1'b1;

      case (st)
        S_IDLE: if (start) begin
          sh       <= sum_a;
          word_b   <= sum_b;
          second   <= 1'b0;
          bcnt     <= '0;
          div      <= '0;
          spi_cs_n <= 1'b0;
          spi_sclk <= 1'b0;
          st       <= S_SHIFT;
        end
        S_SHIFT: begin
          if (div_end) begin
            div <= '0;
            if (!spi_sclk) begin
              spi_sclk <= 1'b1;
            end else begin
              spi_sclk <= 1'b0;
              if (bcnt == BIT_LAST) begin
                spi_cs_n <= 1'b1;
                st       <= S_GAP;
              end else begin
                sh   <= {sh[WORD_W-2:0], 1'b0};
                bcnt <= bcnt + 1'b1;
              end
            end
          end else begin
            div <= div + 1'b1;
          end
        end
        S_GAP: begin
          if (div_end) begin
            div <= '0;
            if (!second) begin
              sh       <= word_b;
              second   <= 1'b1;
              bcnt     <= '0;
              spi_cs_n <= 1'b0;
              st       <= S_SHIFT;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            div <= div + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_fsel_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt == TOG_LAST) |=> (fsel != $past(fsel)));
  a_r2_fsel_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt != TOG_LAST) |=> $stable(fsel));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> (!spi_sclk && !spi_mosi));
  a_r5_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));
  a_r4_cs_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);
endmodule

// File: tb/sim_dds_word_alternator.sv
`timescale 1ns/1ps
module sim_dds_word_alternator;
  localparam int TOG = 5;
  localparam int REF = 1000;
  localparam int DIV = 2;
  localparam int FRAME_GAP = 65 * DIV;

  logic clk = 1'b0, rst_n = 1'b0, upd = 1'b0;
  logic [31:0] base_a = '0, base_b = '0, offset = '0;
  logic spi_sclk, spi_mosi, spi_cs_n, fsel, busy;

  dds_word_alternator #(.WORD_W(32), .TOGGLE_CYC(TOG), .REFRESH_CYC(REF), .SCLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .base_a(base_a), .base_b(base_b), .offset(offset), .upd(upd),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .fsel(fsel), .busy(busy));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, ncyc = 0, wd = 0;
  int rxbits = 0, rxn = 0, badlen = 0, quiet_bad = 0;
  logic [31:0] rxsh = '0;
  logic [31:0] rxw [0:63];
  int falls [0:63];
  logic cs_prev = 1'b1;

  always @(posedge clk) if (rst_n) ncyc++;

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    rxsh = {rxsh[30:0], spi_mosi};
    rxbits++;
  end
  always @(posedge spi_cs_n) if (rxbits != 0) begin
    if (rxbits != 32) badlen++;
    if (rxn < 64) rxw[rxn] = rxsh;
    rxn++;
    rxbits = 0;
  end
  always @(negedge clk) begin
    if (cs_prev === 1'b1 && spi_cs_n === 1'b0 && rxn < 64) falls[rxn] = ncyc;
    cs_prev = spi_cs_n;
    if (rst_n && spi_cs_n === 1'b1 && (spi_sclk !== 1'b0 || spi_mosi !== 1'b0)) quiet_bad++;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    wd++;
    if (wd > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", wd);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wait_words(input int target);
    for (int i = 0; i < 3000 && rxn < target; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  task automatic check_fsel(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(fsel == 1'(((ncyc / TOG) % 2)), "R2", "fsel vs edge count",
          32'(fsel), 32'((ncyc / TOG) % 2));
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] b, input logic [31:0] off);
    int n0;
    @(negedge clk);
    base_a = a; base_b = b; offset = off; upd = 1'b1;
    n0 = rxn;
    @(negedge clk);
    upd = 1'b0;
    chk(busy == 1'b1, "R4", "busy after strobe", 32'(busy), 32'd1);
    wait_words(n0 + 2);
    wait_idle();
    repeat (10) @(negedge clk);
    chk(rxn == n0 + 2, "R4", "frames per write", 32'(rxn - n0), 32'd2);
    chk(rxw[n0] == a + off, "R3", "word A", rxw[n0], a + off);
    chk(rxw[n0+1] == b + off, "R3", "word B", rxw[n0+1], b + off);
    chk(falls[n0+1] - falls[n0] == FRAME_GAP, "R5", "frame spacing",
        32'(falls[n0+1] - falls[n0]), 32'(FRAME_GAP));
  endtask

  logic [31:0] offs [0:6];

  initial begin
    offs[0] = 32'h0; offs[1] = 32'h1; offs[2] = 32'hFFFFFFFF; offs[3] = 32'h7FFFFFFF;
    offs[4] = 32'h80000000; offs[5] = 32'h00000A5A; offs[6] = 32'hFFFF0000;

    repeat (4) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1", "cs_n in reset", 32'(spi_cs_n), 32'd1);
    chk(spi_sclk == 1'b0 && spi_mosi == 1'b0, "R1", "sclk/mosi in reset",
        32'({spi_sclk, spi_mosi}), 32'd0);
    chk(fsel == 1'b0 && busy == 1'b0, "R1", "fsel/busy in reset", 32'({fsel, busy}), 32'd0);
    rst_n = 1'b1;
    check_fsel(60);

    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 7; k++)
        if (p == 0) do_write(32'h440262F6, 32'h43FDCC8E, offs[k]);
        else        do_write(32'hFFFFFFFF, 32'h00000000, offs[k]);

    begin
      int n0;
      n0 = rxn;
      do_write(32'h440262F6, 32'h43FDCC8E, 32'h0);
      chk(rxw[n0] - rxw[n0+1] == 32'h00049668, "R3", "A-B step", rxw[n0] - rxw[n0+1], 32'h00049668);
    end

    begin
      int n0;
      @(negedge clk);
      offset = 32'h00000100; upd = 1'b1;
      n0 = rxn;
      @(negedge clk);
      upd = 1'b0;
      repeat (40) @(negedge clk);
      offset = 32'hFFFFFF00;
      base_a = 32'h12345678;
      repeat (10) @(negedge clk);
      upd = 1'b1;
      @(negedge clk);
      upd = 1'b0;
      chk(busy == 1'b1, "R7", "still busy at held strobe", 32'(busy), 32'd1);
      wait_words(n0 + 2);
      chk(rxw[n0] == 32'h440262F6 + 32'h100, "R6", "first A from start values",
          rxw[n0], 32'h440262F6 + 32'h100);
      chk(rxw[n0+1] == 32'h43FDCC8E + 32'h100, "R6", "first B from start values",
          rxw[n0+1], 32'h43FDCC8E + 32'h100);
      wait_words(n0 + 4);
      wait_idle();
      repeat (20) @(negedge clk);
      chk(rxn == n0 + 4, "R7", "one held write", 32'(rxn - n0), 32'd4);
      chk(rxw[n0+2] == 32'h12345678 + 32'hFFFFFF00, "R7", "held write A",
          rxw[n0+2], 32'h12345678 + 32'hFFFFFF00);
      chk(rxw[n0+3] == 32'h43FDCC8E + 32'hFFFFFF00, "R7", "held write B",
          rxw[n0+3], 32'h43FDCC8E + 32'hFFFFFF00);
    end

    begin
      int n0;
      n0 = rxn;
      repeat (500) @(negedge clk);
      chk(rxn == n0, "R8", "no early refresh", 32'(rxn - n0), 32'd0);
      offset = 32'h00ABCDEF;
      wait_words(n0 + 2);
      wait_idle();
      chk(rxn == n0 + 2, "R8", "refresh frames", 32'(rxn - n0), 32'd2);
      chk(rxw[n0] == 32'h12345678 + 32'h00ABCDEF, "R8", "refresh A",
          rxw[n0], 32'h12345678 + 32'h00ABCDEF);
      chk(rxw[n0+1] == 32'h43FDCC8E + 32'h00ABCDEF, "R8", "refresh B",
          rxw[n0+1], 32'h43FDCC8E + 32'h00ABCDEF);
      chk(falls[n0] - falls[n0-2] == REF, "R8", "refresh interval",
          32'(falls[n0] - falls[n0-2]), 32'(REF));
    end

    check_fsel(40);
    chk(badlen == 0, "R5", "frames not 32 bits", 32'(badlen), 32'd0);
    chk(quiet_bad == 0, "R9", "activity with cs_n high", 32'(quiet_bad), 32'd0);
    summary();
  end
endmodule